// File: doc/BRIEF.md
# Capture/Compare/Event Timer

A general-purpose timer built around one free-running 16-bit up-counter. By default the counter advances on ticks from an 8-bit programmable clock divider. One counter serves three selectable jobs:

- It can latch its value when a qualified edge arrives on an external pin.
- It can signal an output pin and a status flag when it reaches a programmed reference value.
- It can count the external edges themselves instead of divided clock ticks.

The external pin is brought into the clock domain through a short synchronizer before any edge is detected. Capture and reference events set sticky flags. Each flag is cleared by a one-cycle clear strobe, as a write-one-to-clear register would produce. A single interrupt line combines the flags under per-flag enables. All configuration arrives as plain input fields; whatever decodes bus writes into those fields sits outside the block.

Top module: `gp_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `count`, `capture`, `out_pin`, `cap_flag`, `ref_flag` and `irq` are all zero.
- R2: While `enable` is high and the mode is not event mode, `count` increments once every `prescale`+1 clock cycles (every cycle for `prescale` = 0). After N rising edges with `enable` high, `count` equals floor(N/(`prescale`+1)). A cycle with `enable` low clears `count` to zero.
- R3: The counter wraps from 0xFFFF to 0x0000 and otherwise changes only by +1 or to zero.
- R4: In capture mode (`mode` = 0), a qualified edge on `ext_in` sets `cap_flag` and loads `capture` with the value of `count`. That value is the one shown two rising edges after `ext_in` changes, and both outputs update on the third edge. `edge_sel` encodes the qualified edge as 0 rising, 1 falling, 2 both and 3 none. With `edge_sel` = 3 nothing is captured.
- R5: In reference mode (`mode` = 1) with `restart` = 1, the counter runs 0..`ref_value` and returns to 0 on the tick after it equals `ref_value`. On that tick `ref_flag` is set, and with `toggle_mode` = 0 `out_pin` is high for exactly that one cycle.
- R6: With `toggle_mode` = 1, `out_pin` inverts on every reference match instead of pulsing. It returns to 0 whenever `enable` is low.
- R7: With `restart` = 0, a reference match still pulses `out_pin` and sets `ref_flag`, but the counter continues to `ref_value`+1.
- R8: In event mode (`mode` = 2), `count` advances by one per qualified `ext_in` edge (same `edge_sel` encoding as R4) and ignores prescaler ticks.
- R9: `cap_flag` and `ref_flag` stay set until their clear strobe (`clr_cap`, `clr_ref`) is high at a clock edge. A set event in the same cycle as the strobe wins, and the flag stays set.
- R10: `irq` is high exactly when (`cap_flag` and `cap_ie`) or (`ref_flag` and `ref_ie`), evaluated on the registered flags and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run control; low holds counter, divider and output at zero |
| mode | input | 2 | 0 capture, 1 reference, 2 event count, 3 plain count |
| edge_sel | input | 2 | Qualified edge: 0 rising, 1 falling, 2 both, 3 none |
| restart | input | 1 | Clear counter on reference match |
| toggle_mode | input | 1 | 1 toggles `out_pin` on match, 0 pulses it |
| prescale | input | 8 | Divider setting; division ratio is value+1 |
| ref_value | input | 16 | Reference compare value |
| ext_in | input | 1 | Asynchronous external input |
| clr_cap | input | 1 | Clear strobe for `cap_flag` |
| clr_ref | input | 1 | Clear strobe for `ref_flag` |
| cap_ie | input | 1 | Interrupt enable for `cap_flag` |
| ref_ie | input | 1 | Interrupt enable for `ref_flag` |
| count | output | 16 | Current counter value |
| capture | output | 16 | Last captured count |
| out_pin | output | 1 | Compare output |
| cap_flag | output | 1 | Sticky capture flag |
| ref_flag | output | 1 | Sticky reference flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to bring about from the ports is a flag being set in the same cycle as its clear strobe. The set comes from an edge that only reaches the flag logic after the synchronizer delay, so the two events are hard to line up. The bench holds `clr_cap` high across the whole window in which the delayed edge can arrive. It then checks that the flag is still set on the edge where the capture lands and clears on the next one. The wrap case needs the full 65536-cycle run at a divide ratio of one. The divider, reference and edge-select settings are swept, and each expected value comes from modular arithmetic on the cycle count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_CAPTURE   = 2'd0,
    TM_REFERENCE = 2'd1,
    TM_EVENT     = 2'd2,
    TM_PLAIN     = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    EDG_RISE = 2'd0,
    EDG_FALL = 2'd1,
    EDG_BOTH = 2'd2,
    EDG_NONE = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_in,
  input  logic [1:0] edge_sel,
  output logic       evt
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  // stages 0..SYNC_STAGES-1 synchronize, the last stage holds the previous value
  logic [CHAIN_W-1:0] chain;

  for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  logic cur, prev;
  assign cur  = chain[SYNC_STAGES-1];
  assign prev = chain[SYNC_STAGES];

  always_comb begin
    case (edge_sel)
      EDG_RISE: evt = cur & ~prev;
      EDG_FALL: evt = ~cur & prev;
      EDG_BOTH: evt = cur ^ prev;
      default:  evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + PRE_W'(1);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             advance,
  input  logic             ref_mode,
  input  logic             restart,
  input  logic [CNT_W-1:0] ref_value,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  assign match = ref_mode && advance && (count == ref_value);

  always_ff @(posedge clk) begin
    if (rst || !run)         count <= '0;
    else if (advance) begin
      if (match && restart)  count <= '0;
      else                   count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tmr_events.sv
module tmr_events #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cap_evt,
  input  logic             match,
  input  logic [CNT_W-1:0] count,
  input  logic             toggle_mode,
  input  logic             clr_cap,
  input  logic             clr_ref,
  input  logic             cap_ie,
  input  logic             ref_ie,
  output logic [CNT_W-1:0] capture,
  output logic             out_pin,
  output logic             cap_flag,
  output logic             ref_flag,
  output logic             irq
);
  logic cap_next, ref_next;

  // set has priority over the clear strobe
  assign cap_next = (cap_flag & ~clr_cap) | cap_evt;
  assign ref_next = (ref_flag & ~clr_ref) | match;

  always_ff @(posedge clk) begin
    if (rst) begin
      capture  <= '0;
      cap_flag <= 1'b0;
      ref_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (cap_evt) capture <= count;
      cap_flag <= cap_next;
      ref_flag <= ref_next;
      irq      <= (cap_next & cap_ie) | (ref_next & ref_ie);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run)      out_pin <= 1'b0;
    else if (toggle_mode) out_pin <= out_pin ^ match;
    else                  out_pin <= match;
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic [1:0]       edge_sel,
  input  logic             restart,
  input  logic             toggle_mode,
  input  logic [PRE_W-1:0] prescale,
  input  logic [CNT_W-1:0] ref_value,
  input  logic             ext_in,
  input  logic             clr_cap,
  input  logic             clr_ref,
  input  logic             cap_ie,
  input  logic             ref_ie,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             out_pin,
  output logic             cap_flag,
  output logic             ref_flag,
  output logic             irq
);
  logic evt, tick, advance, match, cap_evt, ref_mode;

  tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (ext_in),
    .edge_sel (edge_sel),
    .evt      (evt)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (enable),
    .div  (prescale),
    .tick (tick)
  );

  assign advance  = enable && ((mode == TM_EVENT) ? evt : tick);
  assign ref_mode = (mode == TM_REFERENCE);
  assign cap_evt  = enable && (mode == TM_CAPTURE) && evt;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run       (enable),
    .advance   (advance),
    .ref_mode  (ref_mode),
    .restart   (restart),
    .ref_value (ref_value),
    .count     (count),
    .match     (match)
  );

  tmr_events #(.CNT_W(CNT_W)) u_evt (
    .clk         (clk),
    .rst         (rst),
    .run         (enable),
    .cap_evt     (cap_evt),
    .match       (match),
    .count       (count),
    .toggle_mode (toggle_mode),
    .clr_cap     (clr_cap),
    .clr_ref     (clr_ref),
    .cap_ie      (cap_ie),
    .ref_ie      (ref_ie),
    .capture     (capture),
    .out_pin     (out_pin),
    .cap_flag    (cap_flag),
    .ref_flag    (ref_flag),
    .irq         (irq)
  );
endmodule

// File: rtl/gp_timer_checker.sv
module gp_timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             toggle_mode,
  input logic             clr_cap,
  input logic             cap_ie,
  input logic             ref_ie,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capture,
  input logic             out_pin,
  input logic             cap_flag,
  input logic             ref_flag,
  input logic             irq
);
  // R2
  disabled_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (count == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> (count == $past(count) + CNT_W'(1)) || (count == '0));

  // R4
  capture_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(capture) |-> cap_flag);

  // R5
  pulse_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_pin && !$past(toggle_mode)) |-> ref_flag);

  // R9
  cap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_flag && !clr_cap) |=> cap_flag);

  // R10
  irq_combine_chk: assert property (@(posedge clk) disable iff (rst)
    irq == ((cap_flag && $past(cap_ie)) || (ref_flag && $past(ref_ie))));
endmodule

bind gp_timer gp_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .toggle_mode (toggle_mode),
  .clr_cap     (clr_cap),
  .cap_ie      (cap_ie),
  .ref_ie      (ref_ie),
  .count       (count),
  .capture     (capture),
  .out_pin     (out_pin),
  .cap_flag    (cap_flag),
  .ref_flag    (ref_flag),
  .irq         (irq)
);

// File: tb/gp_timer_test.sv
`timescale 1ns/1ps
module gp_timer_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic [1:0]  mode;
  logic [1:0]  edge_sel;
  logic        restart;
  logic        toggle_mode;
  logic [7:0]  prescale;
  logic [15:0] ref_value;
  logic        ext_in;
  logic        clr_cap;
  logic        clr_ref;
  logic        cap_ie;
  logic        ref_ie;
  logic [15:0] count;
  logic [15:0] capture;
  logic        out_pin;
  logic        cap_flag;
  logic        ref_flag;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gp_timer uut (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode), .edge_sel(edge_sel),
    .restart(restart), .toggle_mode(toggle_mode), .prescale(prescale),
    .ref_value(ref_value), .ext_in(ext_in), .clr_cap(clr_cap), .clr_ref(clr_ref),
    .cap_ie(cap_ie), .ref_ie(ref_ie), .count(count), .capture(capture),
    .out_pin(out_pin), .cap_flag(cap_flag), .ref_flag(ref_flag), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit qualified(input int sel, input bit rising);
    case (sel)
      0: return rising;
      1: return !rising;
      2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] seen;
    logic [15:0] last_cap;
    int exp_cnt;

    rst = 1'b1; enable = 1'b0; mode = 2'd0; edge_sel = 2'd0; restart = 1'b0;
    toggle_mode = 1'b0; prescale = 8'd0; ref_value = 16'd0; ext_in = 1'b0;
    clr_cap = 1'b0; clr_ref = 1'b0; cap_ie = 1'b0; ref_ie = 1'b0;
    step(3);
    check("R1 count", count, 0);
    check("R1 capture", capture, 0);
    check("R1 flags/out/irq", {out_pin, cap_flag, ref_flag, irq}, 0);
    rst = 1'b0;
    step(1);
    check("R1 after release", {count, capture, out_pin, cap_flag, ref_flag, irq}, 0);

    // R2: divider sweep in plain capture mode with a quiet pin
    foreach (prescale_list[k]) begin
      enable = 1'b0; mode = 2'd0; prescale = prescale_list[k];
      step(1);
      check("R2 disabled clear", count, 0);
      enable = 1'b1;
      step(2 * (prescale_list[k] + 1) - 1);
      check("R2 divided count", count, 1);
      step(1);
      check("R2 divided count", count, 2);
    end

    // R3: wrap at full width
    enable = 1'b0; prescale = 8'd0; step(1);
    enable = 1'b1;
    step(65535);
    check("R3 top value", count, 16'hFFFF);
    step(1);
    check("R3 wrap", count, 0);

    // R5 R6: reference mode with restart, pulse and toggle
    foreach (ref_list[k]) begin
      for (int tog = 0; tog < 2; tog++) begin
        int r;
        r = ref_list[k];
        enable = 1'b0; mode = 2'd1; ref_value = 16'(r); restart = 1'b1;
        toggle_mode = tog[0]; clr_ref = 1'b1;
        step(1);
        clr_ref = 1'b0;
        check("R6 out cleared when disabled", out_pin, 0);
        enable = 1'b1;
        for (int n = 1; n <= 3 * (r + 1) + 1; n++) begin
          step(1);
          check("R5 reference count", count, n % (r + 1));
          if (tog == 1) check("R6 toggle output", out_pin, (n / (r + 1)) % 2);
          else          check("R5 pulse output", out_pin, (n % (r + 1)) == 0);
        end
        check("R5 ref flag set", ref_flag, 1);
      end
    end

    // R7 R10: no restart, reference interrupt
    enable = 1'b0; mode = 2'd1; ref_value = 16'd3; restart = 1'b0; toggle_mode = 1'b0;
    clr_ref = 1'b1; ref_ie = 1'b1;
    step(1);
    clr_ref = 1'b0;
    check("R9 ref flag cleared", ref_flag, 0);
    enable = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      step(1);
      check("R7 continues past reference", count, n);
      check("R7 pulse", out_pin, n == 4);
      check("R10 irq from ref flag", irq, n >= 4);
    end
    ref_ie = 1'b0;
    step(1);
    check("R10 irq masked", irq, 0);
    check("R9 ref flag sticky", ref_flag, 1);

    // R8: event counting per edge select, divider ticks ignored
    for (int sel = 0; sel < 4; sel++) begin
      enable = 1'b0; mode = 2'd2; edge_sel = 2'(sel); prescale = 8'd0; ext_in = 1'b0;
      step(4);
      enable = 1'b1;
      exp_cnt = 0;
      for (int t = 0; t < 6; t++) begin
        ext_in = ~ext_in;
        step(4);
        if (qualified(sel, ext_in)) exp_cnt++;
        check("R8 event count", count, exp_cnt);
      end
    end

    // R4: capture per edge select
    last_cap = capture;
    for (int sel = 0; sel < 4; sel++) begin
      enable = 1'b0; mode = 2'd0; edge_sel = 2'(sel); prescale = 8'd0; ext_in = 1'b0;
      clr_cap = 1'b1;
      step(4);
      clr_cap = 1'b0;
      enable = 1'b1;
      step(5);
      for (int t = 0; t < 4; t++) begin
        ext_in = ~ext_in;
        step(2);
        seen = count;
        step(1);
        if (qualified(sel, ext_in)) begin
          last_cap = seen;
          check("R4 capture flag", cap_flag, 1);
        end else begin
          check("R4 no capture flag", cap_flag, 0);
        end
        check("R4 captured value", capture, last_cap);
        clr_cap = 1'b1;
        step(1);
        clr_cap = 1'b0;
        check("R9 capture flag cleared", cap_flag, 0);
        step(2);
      end
    end

    // R9: set wins over a clear strobe held across the edge window
    enable = 1'b1; mode = 2'd0; edge_sel = 2'd2;
    clr_cap = 1'b1;
    ext_in = ~ext_in;
    step(3);
    check("R9 set beats clear", cap_flag, 1);
    step(1);
    check("R9 clear after set", cap_flag, 0);
    clr_cap = 1'b0;

    // R10: capture interrupt and its mask
    cap_ie = 1'b1;
    ext_in = ~ext_in;
    step(3);
    check("R10 irq from cap flag", irq, 1);
    cap_ie = 1'b0;
    step(1);
    check("R10 irq masked by enable", irq, 0);
    check("R9 cap flag held", cap_flag, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  int prescale_list[6] = '{0, 1, 2, 3, 7, 255};
  int ref_list[4]      = '{0, 1, 2, 5};
endmodule